// File: doc/BRIEF.md
# NAND Command/Address Cycle Sequencer

This block drives one NAND flash operation onto the device bus. The operation is built from a few programmed register words. A start pulse while the sequencer is idle latches those words. The block then issues a command cycle, a programmed number of address cycles and, if one is programmed, a second command cycle. It then waits for the device's ready/busy line to return high. The wait ends in one of two ways: a one-clock done pulse, or a sticky error flag when a programmable timeout runs out first.

Every bus cycle has the same shape. The write-enable strobe is held low for a programmed number of clocks and then high for the same number. The latch-enable line (command or address) and the 8-bit data output stay steady through the whole cycle, so they are stable around the rising strobe edge. One of four chip-enable lines is held low from the first cycle to the end of the ready wait. The line is picked by a field in the upper address word.

Top module: `nand_cycle_seq`

## Requirements
- R1: A `start` pulse seen while idle latches `cmd_word`, `addr_word0`, `addr_word1`, `we_width` and `rdy_limit`. The next clock begins a command cycle with `cle`=1, `ale`=0 and `io_out`=`cmd_word[7:0]`.
- R2: Each bus cycle drives `we_n` low for W clocks and then high for W clocks. W is `we_width`, and a value of 0 counts as 1. `cle`, `ale` and `io_out` do not change while the cycle lasts.
- R3: After the first command, `cmd_word[31:28]` address cycles follow with `ale`=1. Byte k comes from this list, in order: `addr_word0[7:0]`, `addr_word0[15:8]`, `addr_word0[23:16]`, `addr_word0[31:24]`, `addr_word1[7:0]`. Any byte beyond the fifth is 0x00.
- R4: After the address cycles, a command cycle carrying `cmd_word[15:8]` is issued only when that byte is nonzero.
- R5: `addr_word1[31:30]` selects the chip: `ce_n[k]`=0 for k equal to that value, from the first cycle through the ready wait. At all other times every bit of `ce_n` is 1.
- R6: After the last cycle the block samples `rdy_i` on every clock. On the first clock that finds it high, `done` pulses for exactly one clock on the next clock and the block goes idle.
- R7: If `rdy_i` stays low for `rdy_limit`+1 clocks of the wait, `err` is set, no `done` pulse is produced and the block goes idle. `err` stays set until the next accepted start.
- R8: A `start` pulse while `busy`=1 is ignored, and the operation in progress runs unchanged.
- R9: `cmd_word[27:16]` (including the page-size code in bits 25:23) and `addr_word1[29:8]` have no effect on the bus cycles.
- R10: After reset, `ce_n`=4'hF, `we_n`=1, `cle`=0, `ale`=0, `io_out`=0, and `busy`, `done` and `err` are all 0.
- R11: `cle` and `ale` are never high together. When neither is high, `we_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (honoured only when idle) |
| cmd_word | input | 32 | First opcode [7:0], second opcode [15:8], address count [31:28] |
| addr_word0 | input | 32 | Column [15:0], page bits 15:0 in [31:16] |
| addr_word1 | input | 32 | Page bits 23:16 in [7:0], chip select [31:30] |
| we_width | input | 4 | Clocks per strobe phase (0 treated as 1) |
| rdy_limit | input | 16 | Ready-wait timeout in clocks |
| rdy_i | input | 1 | Device ready (1) / busy (0) |
| ce_n | output | 4 | Active-low chip enables |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Active-low write strobe |
| io_out | output | 8 | Bus byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Ready-wait timeout flag |

## Verification
Some properties are checked by assertions on every cycle. The bus byte and both latch enables hold still at each rising strobe edge. Cle and ale are never high together, and the bus stays quiet when idle. At most one chip enable is low. Done lasts one clock and follows a sampled ready. The wait counter never passes its limit. Other behaviour can only be shown by the bench scenarios. These cover the exact byte order and zero fill of the address bytes, and whether the second command is present or omitted. They also cover the strobe width for several settings, the exact clock of done after a late ready, the timeout, a start pulse ignored mid-operation, and the field bits that are ignored.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CMD1 = 3'd1,
    ST_ADDR = 3'd2,
    ST_CMD2 = 3'd3,
    ST_WAIT = 3'd4
  } seq_state_e;

  localparam int OPC_W = 8;
endpackage

// File: rtl/nand_we_timer.sv
module nand_we_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [CNT_W-1:0] width,
  output logic             we_low,
  output logic             cycle_end
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hi_q, hi_d;
  logic [CNT_W-1:0] lim;
  logic             at_lim;

  assign lim    = (width == '0) ? CNT_W'(1) : width;
  assign at_lim = (cnt_q == (lim - CNT_W'(1)));

  always_comb begin
    cnt_d = cnt_q;
    hi_d  = hi_q;
    if (!active) begin
      cnt_d = '0;
      hi_d  = 1'b0;
    end else if (at_lim) begin
      cnt_d = '0;
      hi_d  = ~hi_q;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      hi_q  <= hi_d;
    end
  end

  assign we_low    = active & ~hi_q;
  assign cycle_end = active & hi_q & at_lim;

  AST_PHASE_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q < lim)); // R2
endmodule

// File: rtl/nand_rdy_wait.sv
module nand_rdy_wait #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic            rdy,
  input  logic [TO_W-1:0] limit,
  output logic            timeout
);
  logic [TO_W-1:0] cnt_q, cnt_d;
  logic            hit;

  assign hit = (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (!arm)
      cnt_d = '0;
    else if (!rdy && !hit)
      cnt_d = cnt_q + TO_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign timeout = arm & ~rdy & hit;

  AST_WAIT_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> (cnt_q <= limit)); // R7
endmodule

// File: rtl/nand_addr_pick.sv
module nand_addr_pick #(
  parameter int COL_BYTES = 2,
  parameter int ROW_BYTES = 3,
  parameter int IDX_W     = 4
) (
  input  logic [COL_BYTES*8-1:0] col,
  input  logic [ROW_BYTES*8-1:0] row,
  input  logic [IDX_W-1:0]       idx,
  output logic [7:0]             byte_o
);
  localparam int TOTAL = COL_BYTES + ROW_BYTES;

  logic [7:0] lane [TOTAL];

  for (genvar g = 0; g < COL_BYTES; g++) begin : g_col
    assign lane[g] = col[g*8 +: 8];
  end
  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_row
    assign lane[COL_BYTES+g] = row[g*8 +: 8];
  end

  always_comb begin
    byte_o = 8'h00;
    for (int k = 0; k < TOTAL; k++)
      if (idx == IDX_W'(k)) byte_o = lane[k];
  end
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_seq_pkg::*;
#(
  parameter int NUM_CE = 4,
  parameter int WID_W  = 4,
  parameter int TO_W   = 16,
  parameter int ACNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       cmd_word,
  input  logic [31:0]       addr_word0,
  input  logic [31:0]       addr_word1,
  input  logic [WID_W-1:0]  we_width,
  input  logic [TO_W-1:0]   rdy_limit,
  input  logic              rdy_i,
  output logic [NUM_CE-1:0] ce_n,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic [7:0]        io_out,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int CS_W  = (NUM_CE > 1) ? $clog2(NUM_CE) : 1;
  localparam int COL_B = 2;
  localparam int ROW_B = 3;

  seq_state_e        state_q, state_d;
  logic [OPC_W-1:0]  op1_q, op2_q;
  logic [ACNT_W-1:0] acnt_q, aidx_q, aidx_d;
  logic [COL_B*8-1:0] col_q;
  logic [ROW_B*8-1:0] row_q;
  logic [CS_W-1:0]   cs_q;
  logic [WID_W-1:0]  width_q;
  logic [TO_W-1:0]   lim_q;
  logic              done_q, done_d, err_q, err_d, load;
  logic              bus_active, we_low, cyc_end, tout;
  logic [7:0]        addr_byte;
  logic              unused_bits;

  assign unused_bits = ^{cmd_word[27:16], addr_word1[29:8]};

  nand_we_timer #(.CNT_W(WID_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .active(bus_active), .width(width_q),
    .we_low(we_low), .cycle_end(cyc_end)
  );

  nand_rdy_wait #(.TO_W(TO_W)) i_wait (
    .clk(clk), .rst_n(rst_n), .arm(state_q == ST_WAIT), .rdy(rdy_i),
    .limit(lim_q), .timeout(tout)
  );

  nand_addr_pick #(.COL_BYTES(COL_B), .ROW_BYTES(ROW_B), .IDX_W(ACNT_W)) i_pick (
    .col(col_q), .row(row_q), .idx(aidx_q), .byte_o(addr_byte)
  );

  always_comb begin
    state_d = state_q;
    aidx_d  = aidx_q;
    done_d  = 1'b0;
    err_d   = err_q;
    load    = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_CMD1;
        err_d   = 1'b0;
        load    = 1'b1;
      end
      ST_CMD1: if (cyc_end) begin
        aidx_d = '0;
        if (acnt_q != '0)     state_d = ST_ADDR;
        else if (op2_q != '0) state_d = ST_CMD2;
        else                  state_d = ST_WAIT;
      end
      ST_ADDR: if (cyc_end) begin
        if (aidx_q == (acnt_q - ACNT_W'(1)))
          state_d = (op2_q != '0) ? ST_CMD2 : ST_WAIT;
        else
          aidx_d = aidx_q + ACNT_W'(1);
      end
      ST_CMD2: if (cyc_end) state_d = ST_WAIT;
      ST_WAIT: begin
        if (rdy_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else if (tout) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      aidx_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      aidx_q  <= aidx_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op1_q   <= '0;
      op2_q   <= '0;
      acnt_q  <= '0;
      col_q   <= '0;
      row_q   <= '0;
      cs_q    <= '0;
      width_q <= '0;
      lim_q   <= '0;
    end else if (load) begin
      op1_q   <= cmd_word[7:0];
      op2_q   <= cmd_word[15:8];
      acnt_q  <= cmd_word[31 -: ACNT_W];
      col_q   <= addr_word0[15:0];
      row_q   <= {addr_word1[7:0], addr_word0[31:16]};
      cs_q    <= addr_word1[31 -: CS_W];
      width_q <= we_width;
      lim_q   <= rdy_limit;
    end
  end

  assign bus_active = (state_q == ST_CMD1) || (state_q == ST_ADDR) || (state_q == ST_CMD2);
  assign busy   = (state_q != ST_IDLE);
  assign cle    = (state_q == ST_CMD1) || (state_q == ST_CMD2);
  assign ale    = (state_q == ST_ADDR);
  assign we_n   = ~we_low;
  assign done   = done_q;
  assign err    = err_q;

  always_comb begin
    case (state_q)
      ST_CMD1: io_out = op1_q;
      ST_CMD2: io_out = op2_q;
      ST_ADDR: io_out = addr_byte;
      default: io_out = 8'h00;
    endcase
  end

  for (genvar k = 0; k < NUM_CE; k++) begin : g_ce
    assign ce_n[k] = ~(busy && (cs_q == CS_W'(k)));
  end

  AST_BUS_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> ($stable(io_out) && $stable(cle) && $stable(ale))); // R2
  AST_CE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ce_n)); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_AFTER_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rdy_i)); // R6
  AST_ERR_WITHOUT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !done); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cle && !ale) |-> we_n); // R11
endmodule

// File: tb/test_nand_cycle_seq.sv
`timescale 1ns/1ps
module test_nand_cycle_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] cmd_word = '0, addr_word0 = '0, addr_word1 = '0;
  logic [3:0]  we_width = '0;
  logic [15:0] rdy_limit = '0;
  logic        rdy_i = 1'b1;
  logic [3:0]  ce_n;
  logic        cle, ale, we_n, busy, done, err;
  logic [7:0]  io_out;

  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  nand_cycle_seq i_nand_cycle_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_word(cmd_word),
    .addr_word0(addr_word0), .addr_word1(addr_word1), .we_width(we_width),
    .rdy_limit(rdy_limit), .rdy_i(rdy_i), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .io_out(io_out), .busy(busy), .done(done), .err(err)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  localparam logic [10:0] IDLE_V = {1'b0, 1'b0, 1'b1, 8'h00};
  logic [10:0] mq[$];
  logic [10:0] m_cur = IDLE_V;
  int          m_mode = 0, m_wc = 0;
  int          m_lim = 0;
  logic [1:0]  m_cs = '0;
  logic        m_done = 1'b0, m_err = 1'b0;

  function automatic logic [7:0] ref_byte(int i, logic [31:0] a0, logic [31:0] a1);
    case (i)
      0: return a0[7:0];
      1: return a0[15:8];
      2: return a0[23:16];
      3: return a0[31:24];
      4: return a1[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic push_cycle(logic c, logic a, logic [7:0] b, int w);
    for (int j = 0; j < w; j++) mq.push_back({c, a, 1'b0, b});
    for (int j = 0; j < w; j++) mq.push_back({c, a, 1'b1, b});
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; mq.delete(); m_cur = IDLE_V; m_done = 0; m_err = 0;
    end else begin
      m_done = 0;
      case (m_mode)
        0: if (start) begin
          int w;
          w = (we_width == 0) ? 1 : int'(we_width);
          push_cycle(1'b1, 1'b0, cmd_word[7:0], w);
          for (int i = 0; i < int'(cmd_word[31:28]); i++)
            push_cycle(1'b0, 1'b1, ref_byte(i, addr_word0, addr_word1), w);
          if (cmd_word[15:8] != 0) push_cycle(1'b1, 1'b0, cmd_word[15:8], w);
          m_cs = addr_word1[31:30];
          m_lim = int'(rdy_limit);
          m_err = 0;
          m_mode = 1;
          m_cur = mq.pop_front();
        end
        1: if (mq.size() > 0) m_cur = mq.pop_front();
           else begin m_mode = 2; m_wc = 0; m_cur = IDLE_V; end
        default: begin
          if (rdy_i) begin m_done = 1; m_mode = 0; end
          else if (m_wc == m_lim) begin m_err = 1; m_mode = 0; end
          else m_wc++;
        end
      endcase
    end
  end

  // ---------------- per-clock comparison and monitors ----------------
  logic [10:0] obs[$];
  logic        prev_we = 1'b1;
  int          n_done = 0, n_viol = 0, low_run = 0, low_min = 99, low_max = 0;
  logic [3:0]  ce_seen = 4'hF;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] exp_ce;
      exp_ce = (m_mode == 0) ? 4'hF : ~(4'b0001 << m_cs);
      check("R1/R2/R3/R4 bus", {21'd0, cle, ale, we_n, io_out}, {21'd0, m_cur});
      check("R5 ce_n", {28'd0, ce_n}, {28'd0, exp_ce});
      check("R6/R7/R8 flags", {29'd0, busy, done, err},
            {29'd0, (m_mode != 0), m_done, m_err});
      if (!we_n && prev_we) obs.push_back({cle, ale, we_n, io_out});
      if (!we_n) low_run++;
      else if (low_run > 0) begin
        if (low_run < low_min) low_min = low_run;
        if (low_run > low_max) low_max = low_run;
        low_run = 0;
      end
      prev_we = we_n;
      if (done) n_done++;
      if (busy) ce_seen = ce_n;
      if ((cle && ale) || (!cle && !ale && !we_n)) n_viol++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_op(logic [31:0] c, logic [31:0] a0, logic [31:0] a1,
                        logic [3:0] w, logic [15:0] lim, bit poke);
    obs.delete(); n_done = 0; low_min = 99; low_max = 0;
    @(negedge clk);
    cmd_word = c; addr_word0 = a0; addr_word1 = a1; we_width = w; rdy_limit = lim;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      cmd_word = 32'h0000_9999; addr_word1 = 32'h0000_0000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int k = 0; k < 4000 && !(done || err); k++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_obs(string tag, logic [10:0] exp[$]);
    check({tag, " cycle count"}, obs.size(), exp.size());
    for (int i = 0; i < exp.size() && i < obs.size(); i++)
      check(tag, {21'd0, obs[i]}, {21'd0, exp[i]});
  endtask

  initial begin
    logic [10:0] e[$];
    repeat (4) @(negedge clk);
    // R10: reset state
    check("R10 reset", {ce_n, cle, ale, we_n, io_out, busy, done, err},
          {4'hF, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release", {28'd0, ce_n}, 32'hF);

    // R1 R3 R4 R5 R8: five address bytes, second opcode, start poked mid-run
    run_op(32'h5080_3000, 32'hABCD_1234, 32'h8000_00EF, 4'd2, 16'd50, 1'b1);
    e = '{ {3'b100, 8'h00}, {3'b010, 8'h34}, {3'b010, 8'h12}, {3'b010, 8'hCD},
           {3'b010, 8'hAB}, {3'b010, 8'hEF}, {3'b100, 8'h30} };
    check_obs("R1/R3/R4/R8 read order", e);
    check("R5 chip select 2", {28'd0, ce_seen}, 32'hB);
    check("R6 one done", n_done, 1);
    check("R2 low width 2", low_max, 2);

    // R4 R2 R6: no address, no second opcode, width 0 -> 1, ready late
    rdy_i = 1'b0;
    fork begin repeat (12) @(negedge clk); rdy_i = 1'b1; end join_none
    run_op(32'h0000_00FF, 32'h0, 32'h4000_0000, 4'd0, 16'd200, 1'b0);
    e = '{ {3'b100, 8'hFF} };
    check_obs("R4 single command", e);
    check("R2 width zero as one", low_max, 1);
    check("R6 late ready done", n_done, 1);
    check("R5 chip select 1", {28'd0, ce_seen}, 32'hD);

    // R3: count beyond five gives zero bytes, width 3
    run_op(32'h7000_1080, 32'h5566_7788, 32'h0000_0099, 4'd3, 16'd10, 1'b0);
    e = '{ {3'b100, 8'h80}, {3'b010, 8'h88}, {3'b010, 8'h77}, {3'b010, 8'h66},
           {3'b010, 8'h55}, {3'b010, 8'h99}, {3'b010, 8'h00}, {3'b010, 8'h00},
           {3'b100, 8'h10} };
    check_obs("R3 zero fill", e);
    check("R2 low width 3 min", low_min, 3);
    check("R2 low width 3 max", low_max, 3);

    // R7: timeout with ready held low
    rdy_i = 1'b0;
    run_op(32'h3000_D060, 32'h0012_3456, 32'hC000_0000, 4'd1, 16'd10, 1'b0);
    check("R7 err set", {31'd0, err}, 32'd1);
    check("R7 no done", n_done, 0);
    check("R5 chip select 3", {28'd0, ce_seen}, 32'h7);
    repeat (5) @(negedge clk);
    check("R7 err sticky", {31'd0, err}, 32'd1);
    rdy_i = 1'b1;

    // R9: page-size code and spare bits ignored; R7 err cleared by start
    run_op(32'h5EFF_3000, 32'hABCD_1234, 32'hBFFF_FFEF, 4'd2, 16'd50, 1'b0);
    e = '{ {3'b100, 8'h00}, {3'b010, 8'h34}, {3'b010, 8'h12}, {3'b010, 8'hCD},
           {3'b010, 8'hAB}, {3'b010, 8'hEF}, {3'b100, 8'h30} };
    check_obs("R9 ignored fields", e);
    check("R7 err cleared", {31'd0, err}, 32'd0);
    check("R11 strobe rules", n_viol, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule